// File: doc/BRIEF.md
# Chip-Select Area Decoder with Default Fallback

This block turns a 24-bit bus address into a chip-select decision. Four programmable areas are each described by a base value and a don't-care mask. The area-2 slot can instead cover a fixed wide range made of two pieces. When no enabled area claims the address, the access falls to a default area, whose bus attributes are always in force.

For the selected area, or for the default, the block drives active-low one-hot chip selects, the area index, the 3-bit wait code and the bus-width bit. A downstream wait generator consumes these. Registers are loaded through a plain synchronous write port. The decode is combinational. A second copy of the chip selects and the index is captured on an address strobe.

Top module: `csd_decoder`

## Requirements
- R1: After reset every area is disabled and the area-2 mode bit is 0. With no writes, any address selects the default area: `cs_n` = 4'hF, `sel_idx` = 4, wait code 3'b000, `bus_wide` = 0. The registered outputs reset to `cs_q_n` = 4'hF and `sel_q` = 4.
- R2: An enabled area in start/mask mode matches when `((addr ^ start) & ~mask) == 0`. A mask bit of 1 marks a don't-care position.
- R3: An area whose enable bit (control bit 7) is 0 never asserts its chip select.
- R4: When several areas match, the lowest index wins. At most one bit of `cs_n` is low, and `sel_idx` names the area whose select is low.
- R5: With area 2 enabled and its mode bit (control bit 6) at 0, area 2 matches exactly the ranges 0x000FE0..0x000FFF and 0x003000..0xFFFFFF.
- R6: With the area-2 mode bit at 1, area 2 matches through its start and mask values, and the fixed ranges no longer apply.
- R7: When no area matches, `cs_n` is all ones and `sel_idx` = 4. `wait_code` and `bus_wide` then come from bits 2:0 and bit 3 of the default control register.
- R8: When an area is selected, `wait_code` is bits 2:0 of its control register and `bus_wide` is bit 3.
- R9: On a clock edge with `addr_strobe` high, `cs_q_n` and `sel_q` take the current `cs_n` and `sel_idx`. Without the strobe they hold their value.
- R10: The write address is decoded as follows:
  - If bit 4 is 1, the write goes to the default control register.
  - Otherwise bits 3:2 pick the area and bits 1:0 pick the register: 0 is start, 1 is mask, 2 is control (data bits 7:0).
  - Register code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register select for writes |
| wr_data | input | 24 | Write data |
| addr | input | 24 | Bus address to decode |
| addr_strobe | input | 1 | Captures the decode into the registered outputs |
| cs_n | output | 4 | Active-low chip selects, combinational |
| sel_idx | output | 3 | Selected area, 4 for default |
| wait_code | output | 3 | Wait code of the selected area |
| bus_wide | output | 1 | Bus-width bit of the selected area |
| cs_q_n | output | 4 | Registered chip selects |
| sel_q | output | 3 | Registered area index |

## Verification
The assertions check several properties on every cycle:
- at most one chip select is low;
- the index agrees with the low select or names the default;
- a disabled area stays deasserted;
- the strobe either captures the decode or the registered outputs hold.

Only the bench scenarios can show the remaining behaviour:
- that the match follows the start and mask values;
- that the fixed area-2 ranges have the right edges;
- that the mode bit swaps the two area-2 decoders;
- which attribute values reach the outputs;
- that an unused register code leaves the state alone.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int CSD_ADDR_W = 24;
    localparam int CSD_WAIT_W = 3;

    localparam logic [CSD_ADDR_W-1:0] FIX_LO_BEG = 24'h000FE0;
    localparam logic [CSD_ADDR_W-1:0] FIX_LO_END = 24'h000FFF;
    localparam logic [CSD_ADDR_W-1:0] FIX_HI_BEG = 24'h003000;

    // register selector inside one area
    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_MASK  = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } reg_kind_e;

    // control byte: [7] enable, [6] area mode, [5:4] spare, [3] wide, [2:0] wait
    typedef struct packed {
        logic                  enable;
        logic                  area_mode;
        logic [1:0]            spare;
        logic                  wide;
        logic [CSD_WAIT_W-1:0] wait_code;
    } ctrl_t;

    typedef struct packed {
        logic [CSD_ADDR_W-1:0] start;
        logic [CSD_ADDR_W-1:0] mask;
        ctrl_t                 ctrl;
    } area_cfg_t;

    typedef struct packed {
        logic                  wide;
        logic [CSD_WAIT_W-1:0] wait_code;
    } bus_attr_t;

    function automatic logic fixed_range_hit(input logic [CSD_ADDR_W-1:0] a);
        return ((a >= FIX_LO_BEG) && (a <= FIX_LO_END)) || (a >= FIX_HI_BEG);
    endfunction

    function automatic logic masked_hit(input logic [CSD_ADDR_W-1:0] a,
                                        input logic [CSD_ADDR_W-1:0] base,
                                        input logic [CSD_ADDR_W-1:0] dc);
        return ((a ^ base) & ~dc) == '0;
    endfunction

endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
    import csd_pkg::*;
#(
    parameter int N_AREA = 4,
    localparam int IDX_W = (N_AREA > 1) ? $clog2(N_AREA) : 1,
    localparam int WA_W  = IDX_W + 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [WA_W-1:0]               wr_addr,
    input  logic [CSD_ADDR_W-1:0]         wr_data,
    output area_cfg_t [N_AREA-1:0]        cfg,
    output ctrl_t                         dflt
);

    logic       to_dflt;
    logic [IDX_W-1:0] area_pick;
    reg_kind_e  kind;

    assign to_dflt   = wr_addr[WA_W-1];
    assign area_pick = wr_addr[IDX_W+1:2];
    assign kind      = reg_kind_e'(wr_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt <= '0;
        end else if (wr_en && to_dflt) begin
            dflt <= ctrl_t'(wr_data[7:0]);
        end
    end

    for (genvar g = 0; g < N_AREA; g++) begin : g_area
        logic sel_me;
        assign sel_me = wr_en && !to_dflt && (area_pick == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (sel_me) begin
                unique case (kind)
                    REG_START: cfg[g].start <= wr_data;
                    REG_MASK:  cfg[g].mask  <= wr_data;
                    REG_CTRL:  cfg[g].ctrl  <= ctrl_t'(wr_data[7:0]);
                    REG_NONE:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csd_area_match.sv
module csd_area_match
    import csd_pkg::*;
#(
    parameter bit HAS_FIXED = 1'b0
) (
    input  logic [CSD_ADDR_W-1:0] addr,
    input  area_cfg_t             cfg,
    output logic                  hit
);

    logic mask_hit;
    assign mask_hit = masked_hit(addr, cfg.start, cfg.mask);

    if (HAS_FIXED) begin : g_fixed
        logic fix_hit;
        assign fix_hit = fixed_range_hit(addr);
        always_comb begin
            if (cfg.ctrl.area_mode) hit = cfg.ctrl.enable && mask_hit;
            else                    hit = cfg.ctrl.enable && fix_hit;
        end
    end else begin : g_plain
        assign hit = cfg.ctrl.enable && mask_hit;
    end

endmodule

// File: rtl/csd_select.sv
module csd_select
    import csd_pkg::*;
#(
    parameter int N_AREA = 4,
    localparam int SEL_W = $clog2(N_AREA + 1)
) (
    input  logic [N_AREA-1:0]      hit,
    input  area_cfg_t [N_AREA-1:0] cfg,
    input  ctrl_t                  dflt,
    output logic [N_AREA-1:0]      cs_n,
    output logic [SEL_W-1:0]       sel_idx,
    output bus_attr_t              attr
);

    always_comb begin
        cs_n           = '1;
        sel_idx        = SEL_W'(N_AREA);
        attr.wide      = dflt.wide;
        attr.wait_code = dflt.wait_code;
        // walk from highest index down so the lowest index wins
        for (int i = N_AREA - 1; i >= 0; i--) begin
            if (hit[i]) begin
                cs_n           = '1;
                cs_n[i]        = 1'b0;
                sel_idx        = SEL_W'(i);
                attr.wide      = cfg[i].ctrl.wide;
                attr.wait_code = cfg[i].ctrl.wait_code;
            end
        end
    end

endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
    import csd_pkg::*;
#(
    parameter int N_AREA     = 4,
    parameter int FIXED_AREA = 2,
    localparam int IDX_W = (N_AREA > 1) ? $clog2(N_AREA) : 1,
    localparam int WA_W  = IDX_W + 3,
    localparam int SEL_W = $clog2(N_AREA + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [WA_W-1:0]       wr_addr,
    input  logic [CSD_ADDR_W-1:0] wr_data,
    input  logic [CSD_ADDR_W-1:0] addr,
    input  logic                  addr_strobe,
    output logic [N_AREA-1:0]     cs_n,
    output logic [SEL_W-1:0]      sel_idx,
    output logic [CSD_WAIT_W-1:0] wait_code,
    output logic                  bus_wide,
    output logic [N_AREA-1:0]     cs_q_n,
    output logic [SEL_W-1:0]      sel_q
);

    area_cfg_t [N_AREA-1:0] cfg;
    ctrl_t                  dflt;
    logic [N_AREA-1:0]      hit;
    logic [N_AREA-1:0]      area_en;
    bus_attr_t              attr;

    csd_regfile #(.N_AREA(N_AREA)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .dflt    (dflt)
    );

    for (genvar g = 0; g < N_AREA; g++) begin : g_match
        assign area_en[g] = cfg[g].ctrl.enable;
        csd_area_match #(.HAS_FIXED(g == FIXED_AREA)) u_match (
            .addr (addr),
            .cfg  (cfg[g]),
            .hit  (hit[g])
        );
    end

    csd_select #(.N_AREA(N_AREA)) u_sel (
        .hit     (hit),
        .cfg     (cfg),
        .dflt    (dflt),
        .cs_n    (cs_n),
        .sel_idx (sel_idx),
        .attr    (attr)
    );

    assign wait_code = attr.wait_code;
    assign bus_wide  = attr.wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q_n <= '1;
            sel_q  <= SEL_W'(N_AREA);
        end else if (addr_strobe) begin
            cs_q_n <= cs_n;
            sel_q  <= sel_idx;
        end
    end

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int N_AREA = 4,
    localparam int SEL_W = $clog2(N_AREA + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_strobe,
    input logic [N_AREA-1:0] cs_n,
    input logic [SEL_W-1:0]  sel_idx,
    input logic [N_AREA-1:0] cs_q_n,
    input logic [SEL_W-1:0]  sel_q,
    input logic [N_AREA-1:0] area_en
);

    assert_onehot_cs_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_sel_low_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_idx < SEL_W'(N_AREA)) |-> !cs_n[sel_idx]);

    assert_default_idx_R7: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) == (sel_idx == SEL_W'(N_AREA)));

    for (genvar g = 0; g < N_AREA; g++) begin : g_dis
        assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
            !area_en[g] |-> cs_n[g]);
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> (cs_q_n == $past(cs_n)) && (sel_q == $past(sel_idx)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !addr_strobe |=> $stable(cs_q_n) && $stable(sel_q));

endmodule

bind csd_decoder csd_checker #(.N_AREA(N_AREA)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_strobe (addr_strobe),
    .cs_n        (cs_n),
    .sel_idx     (sel_idx),
    .cs_q_n      (cs_q_n),
    .sel_q       (sel_q),
    .area_en     (area_en)
);

// File: tb/sim_csd_decoder.sv
module sim_csd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] addr = '0;
    logic        addr_strobe = 1'b0;
    logic [3:0]  cs_n;
    logic [2:0]  sel_idx;
    logic [2:0]  wait_code;
    logic        bus_wide;
    logic [3:0]  cs_q_n;
    logic [2:0]  sel_q;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    csd_decoder u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .addr(addr), .addr_strobe(addr_strobe), .cs_n(cs_n), .sel_idx(sel_idx),
        .wait_code(wait_code), .bus_wide(bus_wide), .cs_q_n(cs_q_n), .sel_q(sel_q)
    );

    // shadow state built from the write-port rules
    logic [23:0] m_start [4];
    logic [23:0] m_mask  [4];
    logic [7:0]  m_ctrl  [4];
    logic [7:0]  m_dflt;

    typedef struct {
        logic [3:0]  cs;
        logic [2:0]  sel;
        logic [2:0]  wt;
        logic        wd;
        logic [23:0] a;
        int          req;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t model(input logic [23:0] a, input int req);
        exp_t e;
        logic h;
        e.cs = 4'hF; e.sel = 3'd4; e.wt = m_dflt[2:0]; e.wd = m_dflt[3];
        e.a = a; e.req = req;
        for (int i = 3; i >= 0; i--) begin
            if (i == 2 && !m_ctrl[2][6])
                h = m_ctrl[2][7] && (((a >= 24'h000FE0) && (a <= 24'h000FFF)) || (a >= 24'h003000));
            else
                h = m_ctrl[i][7] && (((a ^ m_start[i]) & ~m_mask[i]) == 24'h0);
            if (h) begin
                e.cs = 4'hF; e.cs[i] = 1'b0; e.sel = 3'(i);
                e.wt = m_ctrl[i][2:0]; e.wd = m_ctrl[i][3];
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] wa, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (wa[4]) m_dflt = d[7:0];
        else case (wa[1:0])
            2'd0: m_start[wa[3:2]] = d;
            2'd1: m_mask[wa[3:2]]  = d;
            2'd2: m_ctrl[wa[3:2]]  = d[7:0];
            default: ;
        endcase
    endtask

    // driver: present an address and queue the expected decode
    task automatic apply(input logic [23:0] a, input int req);
        @(negedge clk);
        addr = a;
        sb.push_back(model(a, req));
    endtask

    // monitor: compare after the following rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(cs_n == e.cs,      e.req, $sformatf("cs_n @%h", e.a),      32'(cs_n),      32'(e.cs));
                check(sel_idx == e.sel,  e.req, $sformatf("sel_idx @%h", e.a),   32'(sel_idx),   32'(e.sel));
                check(wait_code == e.wt, e.req, $sformatf("wait_code @%h", e.a), 32'(wait_code), 32'(e.wt));
                check(bus_wide == e.wd,  e.req, $sformatf("bus_wide @%h", e.a),  32'(bus_wide),  32'(e.wd));
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_start[i] = '0; m_mask[i] = '0; m_ctrl[i] = '0;
        end
        m_dflt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, registered copies and decode of any address
        @(negedge clk);
        check(cs_q_n == 4'hF, 1, "cs_q_n after reset", 32'(cs_q_n), 32'hF);
        check(sel_q == 3'd4,  1, "sel_q after reset",  32'(sel_q),  32'd4);
        apply(24'h000100, 1);   // R1
        apply(24'h003000, 1);   // R1: fixed range idle while area 2 disabled

        // R7 / R10: default attributes through address bit 4
        wr(5'h10, 24'h00000D);
        apply(24'h123456, 7);   // R7

        // R5: area 2 fixed range, enable + wait 6
        wr(5'h0A, 24'h000086);
        apply(24'h000FDF, 5);
        apply(24'h000FE0, 5);
        apply(24'h000FFF, 5);
        apply(24'h001000, 5);
        apply(24'h002FFF, 5);
        apply(24'h003000, 5);
        apply(24'hFFFFFF, 5);

        // R2 / R8: area 0 start/mask, wide, wait 1
        wr(5'h00, 24'h100000);
        wr(5'h01, 24'h00FFFF);
        wr(5'h02, 24'h000089);
        apply(24'h10ABCD, 2);   // R2, R8, beats area 2
        apply(24'h110000, 2);   // R2 outside mask -> area 2

        // R4: area 1 overlaps area 0
        wr(5'h04, 24'h100000);
        wr(5'h05, 24'h0FFFFF);
        wr(5'h06, 24'h000082);
        apply(24'h10ABCD, 4);   // R4: area 0 wins
        apply(24'h1A0000, 4);   // R4: area 1 wins over area 2

        // area 3 at 0x8xx
        wr(5'h0C, 24'h000800);
        wr(5'h0D, 24'h0000FF);
        wr(5'h0E, 24'h000087);
        apply(24'h000850, 8);   // R8
        apply(24'h000FE5, 5);   // R5

        // R6: area 2 start/mask mode
        wr(5'h08, 24'h000000);
        wr(5'h09, 24'h000FFF);
        wr(5'h0A, 24'h0000C3);
        apply(24'h000850, 6);   // R6 + R4 over area 3
        apply(24'h005000, 6);   // R6: fixed range gone -> default

        // R3: disable area 0
        wr(5'h02, 24'h000009);
        apply(24'h10ABCD, 3);

        // R10: register code 3 ignored
        wr(5'h07, 24'hFFFFFF);
        wr(5'h03, 24'hFFFFFF);
        apply(24'h1A0000, 10);
        apply(24'h10ABCD, 10);

        // R9: strobe capture and hold
        @(negedge clk);
        addr = 24'h1A0000; addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0; addr = 24'h005000;
        check(cs_q_n == 4'b1101, 9, "cs_q_n capture", 32'(cs_q_n), 32'hD);
        check(sel_q == 3'd1,     9, "sel_q capture",  32'(sel_q),  32'd1);
        repeat (2) @(negedge clk);
        check(cs_q_n == 4'b1101, 9, "cs_q_n hold", 32'(cs_q_n), 32'hD);
        check(sel_q == 3'd1,     9, "sel_q hold",  32'(sel_q),  32'd1);
        addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        check(cs_q_n == 4'hF, 9, "cs_q_n default capture", 32'(cs_q_n), 32'hF);
        check(sel_q == 3'd4,  9, "sel_q default capture",  32'(sel_q),  32'd4);

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule